// File: doc/BRIEF.md
# Fault Action Escalation Controller

This block turns classified fault indications from a high-frequency power stage into a single action level: normal, alarm, derate, shutdown or lockout. Slow trend faults and a degraded return-electrode contact soften the output (derate). Fast or unsafe faults (arc bursts, severe open or short) and leakage or ground-fault cues stop the output at the next clock edge. Each fault input is a level: while it is high the fault is present, and when it goes low the fault has cleared.

After a shutdown the output stays stopped until a cooldown window has passed with no severe fault present. Each automatic restart uses up one unit of a retry budget. A shutdown that expires with the budget spent, or any shutdown caused by leakage, ends in a latched lockout. Only an operator reset, given while every fault input is low, releases the lockout. A fault-free stretch in the normal level refills the budget. Every level change produces a one-cycle event strobe for the logger, carrying the old level, the new level and a cause code. The block also gates the feedback loop's requests for more output.

Top module: `fault_ladder_ctrl`

## Requirements
- R1: While rst_n is low and after it is released, level_o is 0 (normal), stop_o is 0 and evt_o is 0 until a fault input or request arrives.
- R2: Level codes are 0 normal, 1 alarm, 2 derate, 3 shutdown, 4 lockout. When several faults are active together, the most severe action wins. The cause codes, from highest to lowest precedence, are leak 5, hard 4, rem 3, trend 2 and alarm 1, with 0 meaning no fault.
- R3: From normal, alarm or derate, the level at the next edge follows the demanded level. That is 2 if trend_i or rem_i is high, otherwise 1 if alarm_i is high, otherwise 0. The level falls back once the inputs clear.
- R4: A sampled hard_i or leak_i puts the level at 3 or 4 at the next edge. stop_o is 1 exactly when the level is 3 or 4.
- R5: Shutdown is left on the (COOLDOWN+1)-th edge after the last edge at which hard_i or leak_i was sampled high. The level then becomes the demanded level from R3.
- R6: Each restart out of shutdown uses one retry. If a shutdown expires after RETRY_BUDGET restarts have already been used, the block goes to lockout (4) with cause 6.
- R7: A shutdown in which leak_i was seen never restarts. At expiry it goes to lockout with cause 5, whatever the retry count.
- R8: Lockout holds until an edge that samples op_reset_i high with all fault inputs low. The level then goes to 0 with cause 7, and the retry count is cleared.
- R9: After CLEAN_CYCLES consecutive cycles in normal with all fault inputs low, the retry count returns to zero.
- R10: evt_o is high for exactly the one cycle after each level change. In that cycle evt_old_o holds the previous level, evt_new_o holds the current level, and evt_cause_o holds the cause (R2 codes, 0 for a fault-free return, 6, 5 or 7 as above).
- R11: raise_ok_o is high only when raise_req_i is high, the level is 0 or 1, and rem_i is low in the same cycle. A contact fault overrides any request for more output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alarm_i | input | 1 | Advisory fault present |
| trend_i | input | 1 | Slow, controllable trend fault present |
| rem_i | input | 1 | Return-electrode contact fault present |
| hard_i | input | 1 | Fast or unsafe fault present |
| leak_i | input | 1 | Leakage or ground-fault cue present |
| op_reset_i | input | 1 | Operator reset request |
| raise_req_i | input | 1 | Feedback loop asks for more output |
| level_o | output | 3 | Current action level |
| stop_o | output | 1 | Hard stop of the HF output |
| raise_ok_o | output | 1 | Request for more output granted |
| evt_o | output | 1 | Level-change event strobe |
| evt_old_o | output | 3 | Level before the change |
| evt_new_o | output | 3 | Level after the change |
| evt_cause_o | output | 3 | Cause of the change |

## Verification
Two decisions can fall on the same edge: cooldown expiry and the retry-budget or leakage test. A third case also shares an edge: an operator reset that arrives while a fault is still high. The bench lines up shutdowns back to back, so that the budget runs out exactly at an expiry edge. It does the same with a leakage shutdown while retries remain. It also holds a trend fault during an operator reset. In each case it judges the lockout, restart or hold on the exact edge and checks the cause code against a cycle model derived from the requirements. Random streams then make fault arrival, expiry and reset coincide at many more cycles.

// File: rtl/fault_ladder_ctrl.sv
module fault_ladder_ctrl #(
  parameter int COOLDOWN     = 1000,
  parameter int RETRY_BUDGET = 3,
  parameter int CLEAN_CYCLES = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       alarm_i,
  input  logic       trend_i,
  input  logic       rem_i,
  input  logic       hard_i,
  input  logic       leak_i,
  input  logic       op_reset_i,
  input  logic       raise_req_i,
  output logic [2:0] level_o,
  output logic       stop_o,
  output logic       raise_ok_o,
  output logic       evt_o,
  output logic [2:0] evt_old_o,
  output logic [2:0] evt_new_o,
  output logic [2:0] evt_cause_o
);
  localparam int CD_W = $clog2(COOLDOWN + 1);
  localparam int RT_W = $clog2(RETRY_BUDGET + 1);
  localparam int QC_W = $clog2(CLEAN_CYCLES + 1);
  localparam logic [2:0] L_NORM = 3'd0, L_ALRM = 3'd1, L_DRT = 3'd2, L_SHUT = 3'd3, L_LOCK = 3'd4;
  localparam logic [2:0] C_LEAKLOCK = 3'd5, C_EXHAUST = 3'd6, C_OPRST = 3'd7;

  logic [2:0]      lvl, nxt_lvl, nxt_cause, want_lvl, want_cause;
  logic [CD_W-1:0] cd;
  logic [RT_W-1:0] rt;
  logic [QC_W-1:0] qc;
  logic            leak_seen;

  wire severe  = hard_i | leak_i;
  wire any_flt = severe | alarm_i | trend_i | rem_i;
  wire cd_done = (cd == CD_W'(COOLDOWN)) && !severe;

  always_comb begin
    if (leak_i)       {want_lvl, want_cause} = {L_SHUT, 3'd5};
    else if (hard_i)  {want_lvl, want_cause} = {L_SHUT, 3'd4};
    else if (rem_i)   {want_lvl, want_cause} = {L_DRT,  3'd3};
    else if (trend_i) {want_lvl, want_cause} = {L_DRT,  3'd2};
    else if (alarm_i) {want_lvl, want_cause} = {L_ALRM, 3'd1};
    else              {want_lvl, want_cause} = {L_NORM, 3'd0};
  end

  always_comb begin
    nxt_lvl   = lvl;
    nxt_cause = want_cause;
    case (lvl)
      L_LOCK: if (op_reset_i && !any_flt) begin
        nxt_lvl   = L_NORM;
        nxt_cause = C_OPRST;
      end
      L_SHUT: if (cd_done) begin
        if (leak_seen) begin
          nxt_lvl   = L_LOCK;
          nxt_cause = C_LEAKLOCK;
        end else if (rt == RT_W'(RETRY_BUDGET)) begin
          nxt_lvl   = L_LOCK;
          nxt_cause = C_EXHAUST;
        end else begin
          nxt_lvl   = want_lvl;
        end
      end
      default: nxt_lvl = want_lvl;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl         <= L_NORM;
      cd          <= '0;
      rt          <= '0;
      qc          <= '0;
      leak_seen   <= 1'b0;
      evt_o       <= 1'b0;
      evt_old_o   <= '0;
      evt_new_o   <= '0;
      evt_cause_o <= '0;
    end else begin
      lvl   <= nxt_lvl;
      evt_o <= (nxt_lvl != lvl);
      if (nxt_lvl != lvl) begin
        evt_old_o   <= lvl;
        evt_new_o   <= nxt_lvl;
        evt_cause_o <= nxt_cause;
      end
      if (severe)                                 cd <= '0;
      else if (lvl == L_SHUT && !cd_done)         cd <= cd + 1'b1;
      if (nxt_lvl != L_SHUT)                      leak_seen <= 1'b0;
      else if (leak_i)                            leak_seen <= 1'b1;
      if (lvl == L_SHUT && cd_done && !leak_seen && rt != RT_W'(RETRY_BUDGET))
        rt <= rt + 1'b1;
      else if (lvl == L_LOCK && nxt_lvl == L_NORM)
        rt <= '0;
      else if (lvl == L_NORM && !any_flt && qc == QC_W'(CLEAN_CYCLES))
        rt <= '0;
      if (lvl == L_NORM && !any_flt) begin
        if (qc != QC_W'(CLEAN_CYCLES)) qc <= qc + 1'b1;
      end else begin
        qc <= '0;
      end
    end
  end

  assign level_o    = lvl;
  assign stop_o     = (lvl >= L_SHUT);
  assign raise_ok_o = raise_req_i && (lvl <= L_ALRM) && !rem_i;

  // R4
  hard_stop_chk: assert property (@(posedge clk) disable iff (!rst_n) severe |=> stop_o);
  // R5
  cool_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == L_SHUT && cd != CD_W'(COOLDOWN)) |=> (lvl >= L_SHUT));
  // R6
  retry_cap_chk: assert property (@(posedge clk) disable iff (!rst_n) rt <= RT_W'(RETRY_BUDGET));
  // R8
  lock_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == L_LOCK && !op_reset_i) |=> (lvl == L_LOCK));
  // R10
  evt_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> (evt_new_o == lvl && evt_old_o != lvl));
  // R10
  evt_every_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl != $past(lvl)) |-> evt_o);
  // R11
  rem_block_chk: assert property (@(posedge clk) disable iff (!rst_n) rem_i |-> !raise_ok_o);
endmodule

// File: tb/fault_ladder_ctrl_tb.sv
module fault_ladder_ctrl_tb;
  localparam int CD = 12, BUD = 2, CLN = 40;
  logic clk = 0, rst_n = 0;
  logic alarm_i = 0, trend_i = 0, rem_i = 0, hard_i = 0, leak_i = 0, op_reset_i = 0, raise_req_i = 0;
  logic [2:0] level_o, evt_old_o, evt_new_o, evt_cause_o;
  logic stop_o, raise_ok_o, evt_o;
  int vecs = 0, fails = 0;
  int m_lvl, m_cd, m_rt, m_qc, m_leak, m_evt, m_old, m_new, m_cause;

  always #2.5 clk = ~clk;

  fault_ladder_ctrl #(.COOLDOWN(CD), .RETRY_BUDGET(BUD), .CLEAN_CYCLES(CLN)) u_dut (
    .clk, .rst_n, .alarm_i, .trend_i, .rem_i, .hard_i, .leak_i, .op_reset_i, .raise_req_i,
    .level_o, .stop_o, .raise_ok_o, .evt_o, .evt_old_o, .evt_new_o, .evt_cause_o);

  function automatic int want_level();
    if (leak_i || hard_i) return 3;
    if (rem_i || trend_i) return 2;
    if (alarm_i) return 1;
    return 0;
  endfunction

  function automatic int want_cause();
    if (leak_i) return 5;
    if (hard_i) return 4;
    if (rem_i) return 3;
    if (trend_i) return 2;
    if (alarm_i) return 1;
    return 0;
  endfunction

  // cycle model built from R2..R10
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lvl = 0; m_cd = 0; m_rt = 0; m_qc = 0; m_leak = 0;
      m_evt = 0; m_old = 0; m_new = 0; m_cause = 0;
    end else begin
      int nl, nc, sev, anyf, done;
      sev  = int'(hard_i | leak_i);
      anyf = int'(hard_i | leak_i | rem_i | trend_i | alarm_i);
      done = int'(m_cd == CD && sev == 0);
      nl = m_lvl; nc = want_cause();
      if (m_lvl == 4) begin
        if (op_reset_i && anyf == 0) begin nl = 0; nc = 7; end
      end else if (m_lvl == 3) begin
        if (done != 0) begin
          if (m_leak != 0) begin nl = 4; nc = 5; end
          else if (m_rt == BUD) begin nl = 4; nc = 6; end
          else nl = want_level();
        end
      end else nl = want_level();
      if (m_lvl == 3 && done != 0 && m_leak == 0 && m_rt != BUD) m_rt++;
      else if (m_lvl == 4 && nl == 0) m_rt = 0;
      else if (m_lvl == 0 && anyf == 0 && m_qc == CLN) m_rt = 0;
      if (m_lvl == 0 && anyf == 0) begin if (m_qc != CLN) m_qc++; end else m_qc = 0;
      if (sev != 0) m_cd = 0; else if (m_lvl == 3 && done == 0) m_cd++;
      if (nl != 3) m_leak = 0; else if (leak_i) m_leak = 1;
      m_evt = int'(nl != m_lvl);
      if (nl != m_lvl) begin m_old = m_lvl; m_new = nl; m_cause = nc; end
      m_lvl = nl;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int er;
    er = int'(raise_req_i && m_lvl <= 1 && !rem_i);
    chk(int'(level_o) == m_lvl, "R2 level", level_o, m_lvl);
    chk(int'(stop_o) == int'(m_lvl >= 3), "R4 stop", stop_o, int'(m_lvl >= 3));
    chk(int'(evt_o) == m_evt, "R10 strobe", evt_o, m_evt);
    if (m_evt != 0) begin
      chk(int'(evt_old_o) == m_old, "R10 old", evt_old_o, m_old);
      chk(int'(evt_new_o) == m_new, "R10 new", evt_new_o, m_new);
      chk(int'(evt_cause_o) == m_cause, "R10 cause", evt_cause_o, m_cause);
    end
    chk(int'(raise_ok_o) == er, "R11 raise", raise_ok_o, er);
  endtask

  task automatic tick();
    @(negedge clk);
    compare_all();
  endtask

  task automatic clear_in();
    {alarm_i, trend_i, rem_i, hard_i, leak_i, op_reset_i, raise_req_i} = '0;
  endtask

  // one severe pulse, then wait out shutdown; returns cycles spent in shutdown
  task automatic severe_pulse(input bit leak, output int n);
    hard_i = !leak; leak_i = leak;
    tick();
    hard_i = 0; leak_i = 0;
    n = 0;
    while (level_o == 3'd3 && n < 200) begin n++; tick(); end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1
    chk(level_o == 0 && stop_o == 0 && evt_o == 0, "R1 reset", level_o, 0);
    rst_n = 1;
    tick(); tick();
    chk(level_o == 0 && stop_o == 0 && evt_o == 0, "R1 idle", level_o, 0);
    // R3
    trend_i = 1; tick();
    chk(level_o == 2 && evt_cause_o == 2, "R3 trend derate", level_o, 2);
    trend_i = 0; alarm_i = 1; tick();
    chk(level_o == 1 && evt_old_o == 2, "R3 alarm", level_o, 1);
    alarm_i = 0; tick();
    chk(level_o == 0 && evt_cause_o == 0, "R3 release", level_o, 0);
    // R11 same-cycle contact override
    raise_req_i = 1; #1;
    chk(raise_ok_o == 1, "R11 grant", raise_ok_o, 1);
    rem_i = 1; #1;
    chk(raise_ok_o == 0, "R11 rem blocks", raise_ok_o, 0);
    tick();
    chk(level_o == 2 && evt_cause_o == 3, "R3 rem derate", level_o, 2);
    clear_in(); tick();
    // R5 cooldown length
    severe_pulse(0, n);
    chk(n == CD + 1, "R5 cooldown", n, CD + 1);
    chk(evt_o == 1 && evt_new_o == 0, "R5 restart", evt_new_o, 0);
    // R6 budget exhaustion at expiry (1 used so far)
    severe_pulse(0, n);
    chk(level_o == 0, "R6 second restart", level_o, 0);
    severe_pulse(0, n);
    chk(level_o == 4 && evt_cause_o == 6, "R6 lockout", evt_cause_o, 6);
    // R8 reset refused while a fault is active
    op_reset_i = 1; trend_i = 1; tick(); tick();
    chk(level_o == 4, "R8 held", level_o, 4);
    trend_i = 0; tick();
    chk(level_o == 0 && evt_cause_o == 7, "R8 release", evt_cause_o, 7);
    op_reset_i = 0;
    // R9 budget refill after a quiet stretch
    severe_pulse(0, n); severe_pulse(0, n);
    repeat (CLN + 5) tick();
    severe_pulse(0, n);
    chk(level_o == 0, "R9 refilled", level_o, 0);
    // R7 leak never retried
    repeat (CLN + 5) tick();
    severe_pulse(1, n);
    chk(level_o == 4 && evt_cause_o == 5, "R7 leak lockout", evt_cause_o, 5);
    op_reset_i = 1; tick(); op_reset_i = 0;
    // R2 simultaneous faults
    leak_i = 1; trend_i = 1; alarm_i = 1; hard_i = 1; tick();
    chk(level_o == 3 && evt_cause_o == 5, "R2 leak wins", evt_cause_o, 5);
    hard_i = 0; leak_i = 0; alarm_i = 0; tick();
    chk(level_o == 3, "R4 trend keeps stop", level_o, 3);
    trend_i = 0;
    repeat (CD + 2) tick();
    chk(level_o == 4, "R7 leak after trend", level_o, 4);
    op_reset_i = 1; tick(); clear_in(); tick();
    // random mix
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      alarm_i     = ($urandom % 100) < 10;
      trend_i     = ($urandom % 100) < 8;
      rem_i       = ($urandom % 100) < 5;
      hard_i      = ($urandom % 1000) < 15;
      leak_i      = ($urandom % 1000) < 3;
      op_reset_i  = ($urandom % 100) < 4;
      raise_req_i = ($urandom % 2) == 1;
      if ((i / 500) % 2 == 1) {alarm_i, trend_i, rem_i} = '0;
      tick();
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule